// File: doc/BRIEF.md
# Frame-Timed Register Write Sequencer

This block steps through a short program of 16-bit words held in a small scenario memory. Each step is locked to a free-running frame tick counter that counts from 0 to 4999 and then starts again at 0. A wait word holds the program until the counter reaches a chosen value. A move word then puts one 8-bit value on a register write bus toward a serial peripheral port. Because every instruction takes exactly one tick, a wait placed N ticks before a target event leaves room for N-1 register writes that all finish before that event.

A program may hold several wait/move groups in rising time order, and those groups may cross the frame wrap. A start pulse launches the program from word 0. An all-zero word ends it and returns the block to idle. A wait whose time operand lies outside the frame can never match, so it stops the program and raises an error flag.

Top module: `frame_wr_seq`

## Requirements
- R1: The frame counter resets to 0, advances by one only in cycles where tick_en_i is 1, and goes from 4999 to 0. While tick_en_i is 0 it holds its value, and the program does not advance.
- R2: Encoding. A word with bit 15 = 1 is a wait, and its time operand is in bits 12:0. A word with bit 15 = 0 is a move, with the register address in bits 14:8 and the data in bits 7:0. The word 0x0000 ends the program. A move to address 0 with nonzero data is an ordinary move.
- R3: At most one instruction runs per tick. A wait is released on the tick in which the counter equals its operand. The instruction that follows the wait runs on the next tick.
- R4: A move raises wr_stb_o for exactly one clock, in the cycle after the tick in which it ran, with its address and data on wr_addr_o and wr_data_o. With ticks in every cycle, the k-th move after a wait released at count T gives a strobe while frame_cnt_o reads (T+k+1) mod 5000.
- R5: When the end word runs on a tick, busy_o falls after that tick and no write is produced.
- R6: A start pulse while idle sets busy_o in the next cycle, clears err_o and runs the program from memory address 0. A start pulse while busy_o is 1 is ignored. This includes the cycle in which the end word retires.
- R7: A wait with an operand of 5000 or more sets err_o and clears busy_o when it is reached, and it produces no write. err_o stays set until the next accepted start.
- R8: After reset, busy_o, err_o and wr_stb_o are 0.
- R9: Waits in rising time order that cross the frame wrap (for example 4991, 4998, 63, 699) each release in their own frame position, so writes land on both sides of the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Frame tick enable; one counter step and at most one instruction per cycle in which it is high |
| start_i | input | 1 | Start pulse; begins the program at address 0 when idle |
| mem_addr_o | output | 6 | Scenario memory read address (program counter) |
| mem_data_i | input | 16 | Scenario memory read data, valid in the same cycle |
| wr_stb_o | output | 1 | Register write strobe, one cycle per move |
| wr_addr_o | output | 7 | Register write address |
| wr_data_o | output | 8 | Register write data |
| busy_o | output | 1 | Program running |
| err_o | output | 1 | Set by an out-of-frame wait operand |
| frame_cnt_o | output | 13 | Current frame tick count |

## Verification
Two events can fall in the same clock: the end word retiring on a tick, and a fresh start pulse. The bench makes them meet by raising start_i in exactly the cycle where the counter reads the tick on which the end word runs. It then judges the result by checking that busy_o is low in the following cycles and that no extra writes appear. A second pairing is also tested. A start pulse arrives while a released wait is frozen by a low tick enable. The bench checks that the program neither restarts nor skips ahead, so the writes appear once, at their expected counts.

// File: rtl/seq_pkg.sv
package seq_pkg;

   // Decoded class of one scenario word
   typedef enum logic [1:0] {
      OP_END  = 2'd0,
      OP_WAIT = 2'd1,
      OP_MOVE = 2'd2
   } op_e;

endpackage

// File: rtl/seq_frame_counter.sv
module seq_frame_counter #(
   parameter int FRAME_LEN = 5000,
   parameter int TIME_W    = 13
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   output logic [TIME_W-1:0] cnt_o
);
   localparam logic [TIME_W-1:0] LAST = TIME_W'(FRAME_LEN - 1);

   logic [TIME_W-1:0] cnt_q;

   generate
      if (FRAME_LEN == (1 << TIME_W)) begin : g_natural_wrap
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     cnt_q <= '0;
            else if (tick_i) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_compare_wrap
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     cnt_q <= '0;
            else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

   assign cnt_o = cnt_q;

   AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);  // R1
   AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_q));  // R1
   AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && cnt_q == LAST) |=> cnt_q == '0);  // R1

endmodule

// File: rtl/seq_decode.sv
module seq_decode
   import seq_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int TIME_W = 13,
   parameter int REG_AW = 7,
   parameter int REG_DW = 8
) (
   input  logic [WORD_W-1:0] word_i,
   output op_e               op_o,
   output logic [TIME_W-1:0] wtime_o,
   output logic [REG_AW-1:0] addr_o,
   output logic [REG_DW-1:0] data_o
);
   localparam int OPC_BIT = WORD_W - 1;

   always_comb begin
      if (word_i == '0)         op_o = OP_END;
      else if (word_i[OPC_BIT]) op_o = OP_WAIT;
      else                      op_o = OP_MOVE;
   end

   assign wtime_o = word_i[TIME_W-1:0];
   assign addr_o  = word_i[REG_AW+REG_DW-1:REG_DW];
   assign data_o  = word_i[REG_DW-1:0];

endmodule

// File: rtl/seq_engine.sv
module seq_engine
   import seq_pkg::*;
#(
   parameter int FRAME_LEN = 5000,
   parameter int TIME_W    = 13,
   parameter int MEM_AW    = 6,
   parameter int REG_AW    = 7,
   parameter int REG_DW    = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              start_i,
   input  logic [TIME_W-1:0] cnt_i,
   input  op_e               op_i,
   input  logic [TIME_W-1:0] wtime_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [REG_DW-1:0] data_i,
   output logic [MEM_AW-1:0] pc_o,
   output logic              stb_o,
   output logic [REG_AW-1:0] wr_addr_o,
   output logic [REG_DW-1:0] wr_data_o,
   output logic              busy_o,
   output logic              err_o
);
   localparam logic [TIME_W:0] LIMIT = (TIME_W + 1)'(FRAME_LEN);

   logic [MEM_AW-1:0] pc_q;
   logic              busy_q, err_q, stb_q;
   logic [REG_AW-1:0] addr_q;
   logic [REG_DW-1:0] data_q;
   logic              bad_wait;

   assign bad_wait = ({1'b0, wtime_i} >= LIMIT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pc_q   <= '0;
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         stb_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         stb_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               err_q  <= 1'b0;
               pc_q   <= '0;
            end
         end else if (tick_i) begin
            unique case (op_i)
               OP_END: busy_q <= 1'b0;
               OP_WAIT: begin
                  if (bad_wait) begin
                     err_q  <= 1'b1;
                     busy_q <= 1'b0;
                  end else if (wtime_i == cnt_i) begin
                     pc_q <= pc_q + 1'b1;
                  end
               end
               OP_MOVE: begin
                  stb_q  <= 1'b1;
                  addr_q <= addr_i;
                  data_q <= data_i;
                  pc_q   <= pc_q + 1'b1;
               end
               default: busy_q <= 1'b0;
            endcase
         end
      end
   end

   assign pc_o      = pc_q;
   assign stb_o     = stb_q;
   assign wr_addr_o = addr_q;
   assign wr_data_o = data_q;
   assign busy_o    = busy_q;
   assign err_o     = err_q;

   AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_q) |=> (busy_q && !err_q && pc_q == '0));  // R6
   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && start_i && !tick_i) |=> (busy_q && $stable(pc_q)));  // R6
   AST_STB_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_q |-> $past(tick_i && busy_q));  // R4
   AST_IDLE_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |=> !stb_q);  // R5
   AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |-> !busy_q);  // R7
   AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !tick_i) |=> $stable(pc_q));  // R1

endmodule

// File: rtl/frame_wr_seq.sv
module frame_wr_seq
   import seq_pkg::*;
#(
   parameter int FRAME_LEN = 5000,
   parameter int TIME_W    = 13,
   parameter int WORD_W    = 16,
   parameter int MEM_AW    = 6,
   parameter int REG_AW    = 7,
   parameter int REG_DW    = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_en_i,
   input  logic              start_i,
   output logic [MEM_AW-1:0] mem_addr_o,
   input  logic [WORD_W-1:0] mem_data_i,
   output logic              wr_stb_o,
   output logic [REG_AW-1:0] wr_addr_o,
   output logic [REG_DW-1:0] wr_data_o,
   output logic              busy_o,
   output logic              err_o,
   output logic [TIME_W-1:0] frame_cnt_o
);
   initial begin : param_chk
      assert (FRAME_LEN >= 2 && FRAME_LEN <= (1 << TIME_W))
         else $error("FRAME_LEN does not fit TIME_W");
      assert (REG_AW + REG_DW + 1 <= WORD_W)
         else $error("move fields exceed WORD_W");
      assert (TIME_W + 1 <= WORD_W)
         else $error("wait field exceeds WORD_W");
   end

   logic [TIME_W-1:0] cnt;
   op_e               op;
   logic [TIME_W-1:0] wtime;
   logic [REG_AW-1:0] dec_addr;
   logic [REG_DW-1:0] dec_data;

   seq_frame_counter #(.FRAME_LEN(FRAME_LEN), .TIME_W(TIME_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_en_i),
      .cnt_o (cnt)
   );

   seq_decode #(.WORD_W(WORD_W), .TIME_W(TIME_W), .REG_AW(REG_AW), .REG_DW(REG_DW)) u_dec (
      .word_i (mem_data_i),
      .op_o   (op),
      .wtime_o(wtime),
      .addr_o (dec_addr),
      .data_o (dec_data)
   );

   seq_engine #(.FRAME_LEN(FRAME_LEN), .TIME_W(TIME_W), .MEM_AW(MEM_AW),
                .REG_AW(REG_AW), .REG_DW(REG_DW)) u_eng (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_en_i),
      .start_i  (start_i),
      .cnt_i    (cnt),
      .op_i     (op),
      .wtime_i  (wtime),
      .addr_i   (dec_addr),
      .data_i   (dec_data),
      .pc_o     (mem_addr_o),
      .stb_o    (wr_stb_o),
      .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o),
      .busy_o   (busy_o),
      .err_o    (err_o)
   );

   assign frame_cnt_o = cnt;

endmodule

// File: tb/frame_wr_seq_tb.sv
module frame_wr_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        start = 1'b0;
   logic [5:0]  mem_addr;
   logic [15:0] mem_data;
   logic        wr_stb;
   logic [6:0]  wr_addr;
   logic [7:0]  wr_data;
   logic        busy, err;
   logic [12:0] fcnt;

   logic [15:0] scen [64];
   assign mem_data = scen[mem_addr];

   int n_chk = 0;
   int n_fail = 0;

   int log_n = 0;
   int log_a [16];
   int log_d [16];
   int log_c [16];

   always #4 clk = ~clk;  // 125 MHz

   frame_wr_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .start_i(start),
      .mem_addr_o(mem_addr), .mem_data_i(mem_data),
      .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .busy_o(busy), .err_o(err), .frame_cnt_o(fcnt)
   );

   // write monitor, samples away from the active edge
   always @(negedge clk) begin
      if (wr_stb && log_n < 16) begin
         log_a[log_n] = int'(wr_addr);
         log_d[log_n] = int'(wr_data);
         log_c[log_n] = int'(fcnt);
         log_n = log_n + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_wr(input string tag, input int i, input int a, input int d, input int c);
      chk({tag, " addr"}, log_a[i], a);
      chk({tag, " data"}, log_d[i], d);
      chk({tag, " count"}, log_c[i], c);
   endtask

   function automatic logic [15:0] w_wait(input int t);
      return 16'h8000 | 16'(t);
   endfunction

   function automatic logic [15:0] w_move(input int a, input int d);
      return {1'b0, 7'(a), 8'(d)};
   endfunction

   task automatic clear_scen();
      for (int i = 0; i < 64; i++) scen[i] = 16'h0000;
   endtask

   task automatic go_at(input int c);
      do @(negedge clk); while (int'(fcnt) != c);
      log_n = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 12000 && busy; i++) @(negedge clk);
   endtask

   // R8: reset state
   task automatic t_reset();
      chk("R8 busy", int'(busy), 0);
      chk("R8 err", int'(err), 0);
      chk("R8 stb", int'(wr_stb), 0);
      chk("R1 count at reset", int'(fcnt), 0);
   endtask

   // R9 / R4 / R2: groups across the frame wrap
   task automatic t_wrap();
      clear_scen();
      scen[0]  = w_wait(4991);
      scen[1]  = w_move(7'h10, 8'h06);
      scen[2]  = w_move(7'h11, 8'h01);
      scen[3]  = w_move(7'h12, 8'h04);
      scen[4]  = w_wait(4998);
      scen[5]  = w_move(7'h11, 8'h03);
      scen[6]  = w_move(7'h12, 8'h04);
      scen[7]  = w_wait(63);
      scen[8]  = w_move(7'h11, 8'h05);
      scen[9]  = w_move(7'h12, 8'h04);
      scen[10] = w_wait(699);
      scen[11] = w_move(7'h11, 8'h00);
      go_at(10);
      chk("R6 busy after start", int'(busy), 1);
      wait_idle();
      chk("R9 write count", log_n, 8);
      chk_wr("R4 g1w1", 0, 16'h10, 6, 4993);
      chk_wr("R4 g1w2", 1, 16'h11, 1, 4994);
      chk_wr("R4 g1w3", 2, 16'h12, 4, 4995);
      chk_wr("R9 g2w1", 3, 16'h11, 3, 0);
      chk_wr("R9 g2w2", 4, 16'h12, 4, 1);
      chk_wr("R9 g3w1", 5, 16'h11, 5, 65);
      chk_wr("R9 g3w2", 6, 16'h12, 4, 66);
      chk_wr("R2 g4 zero data move", 7, 16'h11, 0, 701);
      chk("R5 busy falls", int'(busy), 0);
      chk("R5 idle count", int'(fcnt), 702);
   endtask

   // R3 / R2: wait placed 4 ticks early, back-to-back wait release
   task automatic t_early();
      clear_scen();
      scen[0] = w_wait(100);
      scen[1] = w_move(7'h05, 8'h11);
      scen[2] = w_move(7'h00, 8'h5A);
      scen[3] = w_move(7'h7F, 8'hFF);
      scen[4] = w_wait(104);
      scen[5] = w_move(7'h06, 8'h22);
      go_at(30);
      chk("R7 err cleared by start", int'(err), 0);
      wait_idle();
      chk("R3 write count", log_n, 4);
      chk_wr("R3 m1", 0, 5, 8'h11, 102);
      chk_wr("R2 addr0 move", 1, 0, 8'h5A, 103);
      chk_wr("R2 top addr", 2, 7'h7F, 8'hFF, 104);
      chk_wr("R3 release same tick", 3, 6, 8'h22, 106);
   endtask

   // R1 / R6: tick gating, start while busy, start on end word retire
   task automatic t_gate_and_start();
      clear_scen();
      scen[0] = w_wait(2000);
      scen[1] = w_move(7'h22, 8'h33);
      scen[2] = w_move(7'h23, 8'h44);
      go_at(1500);
      do @(negedge clk); while (int'(fcnt) != 2000);
      tick_en = 1'b0;
      start = 1'b1;  // busy: ignored
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 counter frozen", int'(fcnt), 2000);
      chk("R1 no write while frozen", log_n, 0);
      chk("R6 still busy", int'(busy), 1);
      tick_en = 1'b1;
      do @(negedge clk); while (int'(fcnt) != 2003);
      start = 1'b1;  // same cycle the end word retires
      @(negedge clk);
      start = 1'b0;
      chk("R6 start on retire ignored", int'(busy), 0);
      repeat (3) @(negedge clk);
      chk("R6 stays idle", int'(busy), 0);
      chk("R4 gated writes", log_n, 2);
      chk_wr("R4 gated w1", 0, 7'h22, 8'h33, 2002);
      chk_wr("R4 gated w2", 1, 7'h23, 8'h44, 2003);
   endtask

   // R7: out-of-frame wait operand
   task automatic t_bad_wait();
      clear_scen();
      scen[0] = w_wait(5000);
      scen[1] = w_move(7'h01, 8'h01);
      go_at(2100);
      repeat (3) @(negedge clk);
      chk("R7 err set", int'(err), 1);
      chk("R7 busy cleared", int'(busy), 0);
      chk("R7 no write", log_n, 0);
      repeat (3) @(negedge clk);
      chk("R7 err sticky", int'(err), 1);
   endtask

   initial begin
      clear_scen();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 advances on tick", int'(fcnt), 1);
      t_wrap();
      t_gate_and_start();
      t_bad_wait();
      t_early();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule